// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, one destination address at a time, whether a received frame should be kept. A neighbouring parser presents the 48-bit destination address of the frame together with a CRC-32 already computed over those six bytes. One clock later the filter returns an accept decision and a 6-bit status word. The status word says whether the address was broadcast or multicast, whether it hit the multicast hash table, whether it hit an exact-match entry, and which entry matched.

The filter holds four exact-match entries. Entry 0 is the station's own address and entries 1 to 3 are spare multicast slots. It also holds a 64-bit multicast hash table and two control bits: promiscuous and hash enable. All of this state is loaded through a 16-bit register write port and starts cleared after reset. Frame parsing, CRC generation and data movement are done by other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: A lookup presented with `lookup_valid_i` high at a clock edge produces its result after that edge: `res_valid_o` is high for exactly one cycle per lookup. While `res_valid_o` is low, `accept_o` and `status_o` are zero. Back-to-back lookups give back-to-back results.
- R2: After reset every exact-match entry and every hash word is zero and both control bits are clear. In that state only broadcast frames are accepted.
- R3: While control bit 5 (value 0x0020, written at address 0x00) is set, every frame is accepted. The status flags are still reported as usual.
- R4: The all-ones destination is broadcast. It is always accepted, sets status bit 5 and leaves status bit 4 clear.
- R5: A destination whose first byte (`dest_addr_i[47:40]`) has bit 0 set and which is not broadcast is multicast, and sets status bit 4. Multicast alone does not make a frame accepted.
- R6: While control bit 8 (value 0x0100) is set, a multicast frame is looked up in the hash table. The index is `dest_crc_i[31:26]`: index bits [5:4] pick hash word 0 to 3 and bits [3:0] pick the bit within that word. A set bit raises status bit 3 and accepts the frame. With bit 8 clear, or for unicast and broadcast frames, the table has no effect.
- R7: Entry e (0 to 3) is written at addresses 0x10+4e (low word), 0x11+4e (middle) and 0x12+4e (high). In each word, bits [7:0] hold the earlier destination byte and bits [15:8] the next one, so the low word holds bytes 1 and 2 of the address. An equal destination sets status bit 2, puts e in status bits [1:0] and accepts the frame. Bits [1:0] are zero when no entry hits.
- R8: An entry whose three words are all zero is unused and never matches, including against an all-zero destination.
- R9: When several entries match, the lowest index is reported.
- R10: Hash word w is written at address 0x04+w. Writes to any other address (0x01 to 0x03, 0x08 to 0x0F, and the fourth word 0x13+4e of each entry) change nothing.
- R11: With hash enabled and all four hash words at 0xFFFF, every multicast frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register word address |
| wr_data_i | input | 16 | Register write data |
| lookup_valid_i | input | 1 | Destination and CRC are valid this cycle |
| dest_addr_i | input | 48 | Destination address, first byte in [47:40] |
| dest_crc_i | input | 32 | CRC-32 over the destination address |
| res_valid_o | output | 1 | Result valid |
| accept_o | output | 1 | Frame is to be kept |
| status_o | output | 6 | [5] broadcast, [4] multicast, [3] hash hit, [2] exact hit, [1:0] matched entry |

## Verification
Every lookup result is registered once, so it appears after the clock edge that samples `lookup_valid_i`. The bench drives a lookup on a falling edge and reads the result on the next falling edge, half a period after the result register loads. A register write lands at the edge after it is driven. Each scenario therefore finishes its writes before it starts a lookup. A pipelined pair of lookups checks that each result lines up with its own cycle and that the outputs return to zero in the cycle after the last one.

// File: rtl/rx_afilt_pkg.sv
package rx_afilt_pkg;
  localparam int WORD_W      = 16;
  localparam int MAC_W       = 48;
  localparam int CRC_W       = 32;
  localparam int NUM_ENTRIES = 4;
  localparam int HASH_WORDS  = 4;
  localparam int REG_ADDR_W  = 5;

  localparam int ENTRY_WORDS = MAC_W / WORD_W;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int HASH_BITS   = HASH_WORDS * WORD_W;
  localparam int HASH_IDX_W  = $clog2(HASH_BITS);
  localparam int HWORD_SEL_W = $clog2(HASH_WORDS);
  localparam int ENTRY_IDX_W = $clog2(NUM_ENTRIES);
  localparam int STATUS_W    = 4 + ENTRY_IDX_W;

  // control word bits
  localparam int CTRL_PROMISC_BIT = 5;
  localparam int CTRL_HASH_EN_BIT = 8;

  // group bit of the first destination byte
  localparam int GROUP_BIT = MAC_W - 8;

  typedef struct packed {
    logic                   bcast;
    logic                   mcast;
    logic                   hash_hit;
    logic                   exact_hit;
    logic [ENTRY_IDX_W-1:0] idx;
  } rx_status_t;
endpackage

// File: rtl/rx_afilt_cfg.sv
module rx_afilt_cfg
  import rx_afilt_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [REG_ADDR_W-1:0]               wr_addr_i,
  input  logic [WORD_W-1:0]                   wr_data_i,
  output logic                                promisc_o,
  output logic                                hash_en_o,
  output logic [HASH_BITS-1:0]                hash_tbl_o,
  output logic [NUM_ENTRIES-1:0][MAC_W-1:0]   entry_o
);
  localparam logic [1:0] LAST_WORD = 2'(ENTRY_WORDS - 1);

  logic [NUM_ENTRIES-1:0][ENTRY_WORDS-1:0][WORD_W-1:0] ent_q;
  logic [HASH_WORDS-1:0][WORD_W-1:0]                   hash_q;
  logic promisc_q, hash_en_q;

  logic                   sel_ctrl, sel_hash, sel_ent;
  logic [ENTRY_IDX_W-1:0] ent_sel;
  logic [1:0]             word_sel;
  logic [HWORD_SEL_W-1:0] hword_sel;

  // map: 0x00 control, 0x04+w hash word, 0x10+4e+w entry word
  always_comb begin
    ent_sel   = wr_addr_i[2 +: ENTRY_IDX_W];
    word_sel  = wr_addr_i[1:0];
    hword_sel = wr_addr_i[HWORD_SEL_W-1:0];
    sel_ctrl  = wr_en_i && (wr_addr_i == '0);
    sel_hash  = wr_en_i && (wr_addr_i[REG_ADDR_W-1:2] == 3'b001);
    sel_ent   = wr_en_i && wr_addr_i[REG_ADDR_W-1] && (word_sel <= LAST_WORD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      promisc_q <= 1'b0;
      hash_en_q <= 1'b0;
      hash_q    <= '0;
      ent_q     <= '0;
    end else begin
      if (sel_ctrl) begin
        promisc_q <= wr_data_i[CTRL_PROMISC_BIT];
        hash_en_q <= wr_data_i[CTRL_HASH_EN_BIT];
      end
      if (sel_hash) hash_q[hword_sel] <= wr_data_i;
      for (int e = 0; e < NUM_ENTRIES; e++)
        for (int w = 0; w < ENTRY_WORDS; w++)
          if (sel_ent && ent_sel == ENTRY_IDX_W'(e) && word_sel == 2'(w))
            ent_q[e][w] <= wr_data_i;
    end
  end

  assign promisc_o  = promisc_q;
  assign hash_en_o  = hash_en_q;
  assign hash_tbl_o = hash_q;

  // low byte of each word is the earlier address byte
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    for (genvar w = 0; w < ENTRY_WORDS; w++) begin : g_word
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        assign entry_o[e][MAC_W-1 - w*WORD_W - b*8 -: 8] = ent_q[e][w][b*8 +: 8];
      end
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0) |=> (promisc_o == $past(wr_data_i[CTRL_PROMISC_BIT])
                                      && hash_en_o == $past(wr_data_i[CTRL_HASH_EN_BIT]))); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=> ($stable(promisc_o) && $stable(hash_en_o))); // R10
endmodule

// File: rtl/rx_afilt_exact.sv
module rx_afilt_exact
  import rx_afilt_pkg::*;
(
  input  logic [NUM_ENTRIES-1:0][MAC_W-1:0] entry_i,
  input  logic [MAC_W-1:0]                  dest_i,
  output logic                              hit_o,
  output logic [ENTRY_IDX_W-1:0]            idx_o
);
  logic [NUM_ENTRIES-1:0] eq;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign eq[e] = (|entry_i[e]) && (entry_i[e] == dest_i);
  end

  // lowest matching index wins
  always_comb begin
    idx_o = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--)
      if (eq[e]) idx_o = ENTRY_IDX_W'(e);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/rx_afilt_hash.sv
module rx_afilt_hash
  import rx_afilt_pkg::*;
(
  input  logic [HASH_BITS-1:0] hash_tbl_i,
  input  logic [CRC_W-1:0]     crc_i,
  input  logic                 en_i,
  input  logic                 mcast_i,
  output logic                 hit_o
);
  logic [HASH_IDX_W-1:0] idx;

  // word select in the upper index bits, bit select below
  assign idx   = crc_i[CRC_W-1 -: HASH_IDX_W];
  assign hit_o = en_i && mcast_i && hash_tbl_i[idx];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_afilt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic                  lookup_valid_i,
  input  logic [MAC_W-1:0]      dest_addr_i,
  input  logic [CRC_W-1:0]      dest_crc_i,
  output logic                  res_valid_o,
  output logic                  accept_o,
  output logic [STATUS_W-1:0]   status_o
);
  logic                             promisc, hash_en;
  logic [HASH_BITS-1:0]             hash_tbl;
  logic [NUM_ENTRIES-1:0][MAC_W-1:0] entries;
  logic                             ex_hit, hs_hit, is_bcast, is_mcast;
  logic [ENTRY_IDX_W-1:0]           ex_idx;
  rx_status_t                       st_d, st_q;
  logic                             acc_d, acc_q, vld_q;

  rx_afilt_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .promisc_o  (promisc),
    .hash_en_o  (hash_en),
    .hash_tbl_o (hash_tbl),
    .entry_o    (entries)
  );

  rx_afilt_exact u_exact (
    .entry_i (entries),
    .dest_i  (dest_addr_i),
    .hit_o   (ex_hit),
    .idx_o   (ex_idx)
  );

  assign is_bcast = &dest_addr_i;
  assign is_mcast = dest_addr_i[GROUP_BIT] && !is_bcast;

  rx_afilt_hash u_hash (
    .hash_tbl_i (hash_tbl),
    .crc_i      (dest_crc_i),
    .en_i       (hash_en),
    .mcast_i    (is_mcast),
    .hit_o      (hs_hit)
  );

  always_comb begin
    st_d.bcast     = is_bcast;
    st_d.mcast     = is_mcast;
    st_d.hash_hit  = hs_hit;
    st_d.exact_hit = ex_hit;
    st_d.idx       = ex_idx;
    acc_d          = promisc || is_bcast || ex_hit || hs_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      st_q  <= '0;
    end else begin
      vld_q <= lookup_valid_i;
      acc_q <= lookup_valid_i && acc_d;
      st_q  <= lookup_valid_i ? st_d : '0;
    end
  end

  assign res_valid_o = vld_q;
  assign accept_o    = acc_q;
  assign status_o    = st_q;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> res_valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!res_valid_o && !accept_o && status_o == '0)); // R1
  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && promisc) |=> accept_o); // R3
  AST_BCAST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && &dest_addr_i) |=> (accept_o && status_o[5] && !status_o[4])); // R4
  AST_UNICAST_NOT_MCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !dest_addr_i[GROUP_BIT]) |=> !status_o[4]); // R5
  AST_HASH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !hash_en) |=> !status_o[3]); // R6
  AST_HASH_NEEDS_MCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] |-> (status_o[4] && accept_o)); // R6
  AST_IDX_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[2] |-> (status_o[1:0] == '0)); // R7
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        lk_vld = 1'b0;
  logic [47:0] dest = '0;
  logic [31:0] crc = '0;
  logic        res_vld, acc;
  logic [5:0]  st;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_56;
  localparam logic [47:0] MC1     = 48'h01_00_5e_00_00_07;
  localparam logic [47:0] MC2     = 48'h01_00_5e_00_00_99;
  localparam logic [47:0] BCAST   = 48'hff_ff_ff_ff_ff_ff;

  always #2.5 clk = ~clk;

  rx_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lookup_valid_i(lk_vld), .dest_addr_i(dest),
    .dest_crc_i(crc), .res_valid_o(res_vld), .accept_o(acc), .status_o(st)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] word_of(logic [47:0] m, int w);
    return {m[39-16*w -: 8], m[47-16*w -: 8]};
  endfunction

  task automatic set_entry(int e, logic [47:0] m);
    for (int w = 0; w < 3; w++) reg_wr(5'(16 + 4*e + w), word_of(m, w));
  endtask

  // result compared as {res_valid, accept, status}
  task automatic lookup(string req, logic [47:0] d, logic [31:0] c,
                        logic exp_acc, logic [5:0] exp_st);
    @(negedge clk);
    lk_vld = 1'b1; dest = d; crc = c;
    @(negedge clk);
    lk_vld = 1'b0;
    check(req, {res_vld, acc, st}, {1'b1, exp_acc, exp_st});
  endtask

  task automatic t_reset;
    check("R2 reset outputs", {res_vld, acc, st}, 8'h00);
    lookup("R2 unicast after reset", STATION, 32'h0, 1'b0, 6'h00);
    lookup("R8 zero dest vs empty entries", 48'h0, 32'h0, 1'b0, 6'h00);
    lookup("R2 multicast after reset", MC1, 32'h0, 1'b0, 6'h10);
  endtask

  task automatic t_bcast;
    lookup("R4 broadcast", BCAST, 32'hffff_ffff, 1'b1, 6'h20);
  endtask

  task automatic t_station;
    set_entry(0, STATION);
    lookup("R7 station hit", STATION, 32'h0, 1'b1, 6'h04);
    lookup("R7 near miss", OTHER, 32'h0, 1'b0, 6'h00);
  endtask

  task automatic t_multi_exact;
    set_entry(2, MC1);
    lookup("R7 multicast slot 2", MC1, 32'h0, 1'b1, 6'h16);
    lookup("R5 multicast no match", MC2, 32'h0, 1'b0, 6'h10);
  endtask

  task automatic t_priority;
    set_entry(3, MC1);
    lookup("R9 slots 2 and 3", MC1, 32'h0, 1'b1, 6'h16);
    set_entry(1, MC1);
    lookup("R9 slots 1 2 3", MC1, 32'h0, 1'b1, 6'h15);
    set_entry(1, 48'h0);
    lookup("R8 cleared slot 1 unused", MC1, 32'h0, 1'b1, 6'h16);
  endtask

  task automatic t_hash;
    reg_wr(5'h00, 16'h0100);
    reg_wr(5'h06, 16'h0080);              // word 2 bit 7 -> index 0x27
    lookup("R6 hash hit", MC2, 32'h9C00_0000, 1'b1, 6'h18);
    lookup("R6 adjacent bit clear", MC2, 32'h9800_0000, 1'b0, 6'h10);
    lookup("R6 word select", MC2, 32'h1C00_0000, 1'b0, 6'h10);
    lookup("R6 unicast ignores hash", OTHER, 32'h9C00_0000, 1'b0, 6'h00);
    reg_wr(5'h00, 16'h0000);
    lookup("R6 hash disabled", MC2, 32'h9C00_0000, 1'b0, 6'h10);
  endtask

  task automatic t_allmulti;
    reg_wr(5'h00, 16'h0100);
    for (int w = 0; w < 4; w++) reg_wr(5'(4 + w), 16'hffff);
    lookup("R11 all multicast crc0", MC2, 32'h0000_0000, 1'b1, 6'h18);
    lookup("R11 all multicast crc1", 48'h33_33_00_00_00_01, 32'hFC00_0000, 1'b1, 6'h18);
    lookup("R11 unicast still rejected", OTHER, 32'h0, 1'b0, 6'h00);
  endtask

  task automatic t_promisc;
    reg_wr(5'h00, 16'h0020);
    lookup("R3 promisc unicast", OTHER, 32'h0, 1'b1, 6'h00);
    lookup("R3 promisc multicast", MC2, 32'h0, 1'b1, 6'h10);
  endtask

  task automatic t_unmapped;
    reg_wr(5'h00, 16'h0000);
    reg_wr(5'h01, 16'h0120);
    reg_wr(5'h0B, 16'hffff);
    reg_wr(5'h13, 16'hffff);
    lookup("R10 no promisc from 0x01", OTHER, 32'h0, 1'b0, 6'h00);
    lookup("R10 no hash enable", MC2, 32'h0, 1'b0, 6'h10);
    lookup("R10 station intact", STATION, 32'h0, 1'b1, 6'h04);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    lk_vld = 1'b1; dest = BCAST;
    @(negedge clk);
    dest = OTHER;
    check("R1 first of pair", {res_vld, acc, st}, {2'b11, 6'h20});
    @(negedge clk);
    lk_vld = 1'b0;
    check("R1 second of pair", {res_vld, acc, st}, {2'b10, 6'h00});
    @(negedge clk);
    check("R1 idle after pair", {res_vld, acc, st}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bcast();
    t_station();
    t_multi_exact();
    t_priority();
    t_hash();
    t_allmulti();
    t_promisc();
    t_unmapped();
    t_pipeline();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule